// File: doc/BRIEF.md
# Printer Handshake Interrupt Controller

This block watches two status lines coming back from a printer, the acknowledge handshake and the fault indication, and turns events on them into a level interrupt request for the system interrupt handler. Each line first passes through a synchroniser. An edge detector then finds the event, and each event sets its own sticky pending flag. Software clears a flag by writing a one to it.

All control and status is held in one byte-wide register on a simple register bus. A write strobe with write data updates the register. The read data port always shows the current register contents. The register holds a three-bit priority level, an interrupt enable, the choice of acknowledge edge, the two pending flags and a read-only summary bit. The level goes out next to the request so that a downstream arbiter can rank it.

Top module: `prt_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq_req` is low and `irq_level` is 0.
- R2: Register bits 2:0 are a read/write interrupt level, and `irq_level` always equals them.
- R3: Bit 3 is a read/write enable. `irq_req` is high exactly when bit 3 and bit 7 are both 1.
- R4: Bit 4 selects the acknowledge edge. With bit 4 = 0 a rising edge of `ack_in` sets bit 5, and with bit 4 = 1 a falling edge sets it. The other edge has no effect on bit 5.
- R5: Bit 5 (acknowledge pending) clears when a write carries a 1 in bit 5. It stays 0 whenever bit 3 is 0, so a write that clears the enable also clears it, and acknowledge edges are ignored while the block is disabled.
- R6: Bit 6 (fault pending) is set by a falling edge of `fault_in` whatever the enable is. A rising edge does not set it. It clears when a write carries a 1 in bit 6.
- R7: Bit 7 is read-only and reads as bit 5 OR bit 6. A write with 0 in bits 7:5 leaves both pending flags unchanged.
- R8: If an event edge and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R9: An edge on `ack_in` or `fault_in` becomes visible in the register on the third rising clock edge after the input changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ack_in | input | 1 | Printer acknowledge line, asynchronous |
| fault_in | input | 1 | Printer fault line, asynchronous, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Current register contents |
| irq_req | output | 1 | Level interrupt request |
| irq_level | output | 3 | Interrupt priority level |

## Verification
Every bit of internal state can be read on `bus_rdata` in the cycle after it changes, and `irq_req` and `irq_level` are combinational functions of that state. A flag set by mistake, lost, or left uncleared therefore shows at the ports within one clock of the triggering edge or write. A synchroniser that is too short or too long moves the flag-set edge away from the third clock after the input change, and the bench samples on both sides of that edge. The same-cycle collision of set and clear is driven with exact timing so that either order of priority can be seen.

// File: rtl/prt_irq_pkg.sv
package prt_irq_pkg;
  localparam int LVL_W     = 3;
  localparam int REG_W     = 8;
  localparam int BIT_EN    = 3;
  localparam int BIT_POL   = 4;
  localparam int BIT_ACK   = 5;
  localparam int BIT_FLT   = 6;
  localparam int BIT_ANY   = 7;
  localparam int CTRL_W    = BIT_POL + 1;
  localparam int NUM_LINES = 2;
  localparam int LINE_ACK  = 0;
  localparam int LINE_FLT  = 1;
endpackage

// File: rtl/prt_reset_sync.sv
module prt_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = 1'b1;
    for (int j = 1; j < STAGES; j++) begin
      pipe_d[j] = pipe_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/prt_edge_sense.sv
module prt_edge_sense #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;
    logic              cur;

    always_comb begin
      chain_d[0] = raw[i];
      for (int j = 1; j < STAGES; j++) begin
        chain_d[j] = chain_q[j-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign cur     = chain_q[STAGES-1];
    assign rise[i] = cur & ~prev_q;
    assign fall[i] = ~cur & prev_q;
  end
endmodule

// File: rtl/prt_sticky_flag.sv
module prt_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic force_clr,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic d;
  logic upd;

  always_comb begin
    upd = force_clr | set | clr;
    if (force_clr)  d = 1'b0;
    else if (set)   d = 1'b1;
    else            d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/prt_irq_ctrl.sv
module prt_irq_ctrl
  import prt_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in,
  input  logic             fault_in,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] line_rise;
  logic [NUM_LINES-1:0] line_fall;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [CTRL_W-1:0]    ctrl_d;
  logic                 ctrl_en;
  logic                 ack_set;
  logic                 ack_clr;
  logic                 ack_off;
  logic                 flt_set;
  logic                 flt_clr;
  logic                 ack_q;
  logic                 flt_q;
  logic                 any_pend;
  logic                 unused_wr_top;
  logic                 unused_flt_rise;

  prt_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  prt_edge_sense #(.LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .raw   ({fault_in, ack_in}),
    .rise  (line_rise),
    .fall  (line_fall)
  );

  // control field: level, enable, edge select
  always_comb begin
    ctrl_en = bus_wr;
    ctrl_d  = bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // event and clear decode
  always_comb begin
    ack_set = ctrl_q[BIT_POL] ? line_fall[LINE_ACK] : line_rise[LINE_ACK];
    ack_clr = bus_wr & bus_wdata[BIT_ACK];
    ack_off = ctrl_en ? ~ctrl_d[BIT_EN] : ~ctrl_q[BIT_EN];
    flt_set = line_fall[LINE_FLT];
    flt_clr = bus_wr & bus_wdata[BIT_FLT];
  end

  prt_sticky_flag u_ack_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .force_clr (ack_off),
    .set       (ack_set),
    .clr       (ack_clr),
    .q         (ack_q)
  );

  prt_sticky_flag u_flt_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .force_clr (1'b0),
    .set       (flt_set),
    .clr       (flt_clr),
    .q         (flt_q)
  );

  assign any_pend        = ack_q | flt_q;
  assign bus_rdata       = {any_pend, flt_q, ack_q, ctrl_q};
  assign irq_req         = ctrl_q[BIT_EN] & any_pend;
  assign irq_level       = ctrl_q[LVL_W-1:0];
  assign unused_wr_top   = bus_wdata[BIT_ANY];
  assign unused_flt_rise = line_rise[LINE_FLT];
endmodule

// File: rtl/prt_irq_ctrl_chk.sv
module prt_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq_req,
  input logic [2:0] irq_level,
  input logic       flt_set
);
  assert_level_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == bus_rdata[2:0]);

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (bus_rdata[3] && bus_rdata[7]));

  assert_ack_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[3] |-> !bus_rdata[5]);

  assert_fault_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[6] && !flt_set) |=> !bus_rdata[6]);

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6] && !(bus_wr && bus_wdata[6])) |=> bus_rdata[6]);

  assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7] == (bus_rdata[5] || bus_rdata[6]));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_set |=> bus_rdata[6]);
endmodule

bind prt_irq_ctrl prt_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_req   (irq_req),
  .irq_level (irq_level),
  .flt_set   (flt_set)
);

// File: tb/prt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prt_irq_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic       ack_in;
  logic       fault_in;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [2:0] irq_level;

  int checks;
  int errors;
  bit done;

  prt_irq_ctrl u_prt_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_in    (ack_in),
    .fault_in  (fault_in),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_level (irq_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = v;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reg", bus_rdata, 8'h00);
    check("R1 irq", irq_req, 0);
    check("R1 level", irq_level, 0);
  endtask

  task automatic t_level_enable();
    wr(8'h0D);
    check("R2 reg", bus_rdata, 8'h0D);
    check("R2 level", irq_level, 5);
    check("R3 no pending no irq", irq_req, 0);
    wr(8'h0A);
    check("R2 level rewrite", irq_level, 2);
  endtask

  task automatic t_ack_rising();
    wr(8'h08);
    @(negedge clk); ack_in = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 check("R9 not before third edge", bus_rdata[5], 0);
    @(posedge clk);
    #1 check("R9 set on third edge", bus_rdata[5], 1);
    settle();
    check("R4 rising sets ack", bus_rdata, 8'hA8);
    check("R3 irq on", irq_req, 1);
    wr(8'h28);
    check("R5 w1c ack", bus_rdata, 8'h08);
    check("R3 irq off", irq_req, 0);
    @(negedge clk); ack_in = 1'b0;
    settle();
    check("R4 falling ignored pol0", bus_rdata[5], 0);
  endtask

  task automatic t_ack_falling();
    wr(8'h18);
    @(negedge clk); ack_in = 1'b1;
    settle();
    check("R4 rising ignored pol1", bus_rdata[5], 0);
    @(negedge clk); ack_in = 1'b0;
    settle();
    check("R4 falling sets pol1", bus_rdata, 8'hB8);
    wr(8'h10);
    check("R5 disable clears ack", bus_rdata, 8'h10);
    check("R5 irq low", irq_req, 0);
    @(negedge clk); ack_in = 1'b1;
    settle();
    @(negedge clk); ack_in = 1'b0;
    settle();
    check("R5 edge ignored when off", bus_rdata[5], 0);
  endtask

  task automatic t_fault();
    wr(8'h00);
    @(negedge clk); fault_in = 1'b1;
    settle();
    check("R6 rising fault ignored", bus_rdata[6], 0);
    @(negedge clk); fault_in = 1'b0;
    settle();
    check("R6 falling sets fault", bus_rdata, 8'hC0);
    check("R3 disabled no irq", irq_req, 0);
    wr(8'h00);
    check("R7 zero write keeps flag", bus_rdata, 8'hC0);
    wr(8'h0B);
    check("R3 enable gives irq", irq_req, 1);
    check("R2 level with irq", irq_level, 3);
    wr(8'h40);
    check("R6 w1c fault", bus_rdata, 8'h00);
  endtask

  task automatic t_set_wins();
    @(negedge clk); fault_in = 1'b1;
    settle();
    @(negedge clk); fault_in = 1'b0;
    settle();
    check("R8 pre set", bus_rdata[6], 1);
    @(negedge clk); fault_in = 1'b1;
    settle();
    @(negedge clk); fault_in = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(8'h40);
    check("R8 set wins over clear", bus_rdata[6], 1);
    wr(8'h40);
    check("R8 later clear", bus_rdata, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    ack_in    = 1'b0;
    fault_in  = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_level_enable();
    t_ack_rising();
    t_ack_falling();
    t_fault();
    t_set_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule